// File: doc/BRIEF.md
# T1 Transmit Frame Serializer and Line Coder

This block turns 24 octet-wide channel samples plus one framing bit into a serial DS1 frame of 193 bits, one frame every 125 µs at 1.544 Mbit/s. It then drives the result onto a bipolar pair of rail outputs. A bit-rate clock enable advances the frame, so each enabled clock is one bit period.

Software or an upstream block places the next frame's octets and framing bit into a staging store with a one-cycle load strobe. The store is copied into the working frame when the framing bit is sent. A 2-bit zero-suppression select picks one of three schemes at run time: plain alternate-mark-inversion, B8ZS substitution, or forced-ones stuffing of empty octets. The select is sampled once per frame.

An eight-bit look-ahead window in front of the rail drivers lets B8ZS replace zero runs that cross timeslot and frame edges. The rail outputs come with a frame-start strobe and the number of the timeslot that is on the line.

Top module: `t1_tx_coder`

## Requirements
- R1: While rst_n is low, line_pos, line_neg and frame_strobe are 0 and slot_idx is 0.
- R2: Every frame lasts exactly 193 bit enables. frame_strobe is high during the bit period that carries the framing bit and low otherwise. During that bit slot_idx is 0.
- R3: After the framing bit come timeslots 1 to 24, 8 bits each, and slot_idx shows the timeslot on the line. Timeslot k is taken from slot_data[(k-1)*8 +: 8], sent most significant bit (bit 1) first.
- R4: The rail outputs, frame_strobe and slot_idx change only on a clock where bit_en is high. A bit generated at the frame position that bit_en number n starts reaches the rails at bit_en number n+8.
- R5: With no substitution active, a 1 makes a pulse on the rail opposite to the most recent pulse and a 0 makes no pulse. The first pulse after reset is on line_pos. line_pos and line_neg are never high together.
- R6: Mode 2'b01 selects B8ZS. Eight consecutive zeros, all generated under mode 2'b01, are sent as 0,0,0,V,B,0,V,B. V has the polarity of the most recent pulse and B the opposite, and every substituted pulse becomes the new most recent pulse.
- R7: Mode 2'b10 selects forced-ones stuffing. A timeslot octet equal to 0 is sent with its last bit (bit 8) set to 1. The framing bit is never altered.
- R8: Modes 2'b00 and 2'b11 select plain AMI. zs_mode is sampled on the bit enable that sends the framing bit and governs that whole frame.
- R9: frame_load captures slot_data and fbit into a staging store. The frame in progress is unaffected, and the staged values are used from the next framing bit onward.
- R10: B8ZS substitution applies to zero runs that span a timeslot boundary or the boundary between two frames sent under mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate clock enable, one bit period per high cycle |
| frame_load | input | 1 | Captures slot_data and fbit into the staging store |
| slot_data | input | 192 | 24 octets, timeslot k in bits (k-1)*8 +: 8 |
| fbit | input | 1 | Framing bit for the staged frame |
| zs_mode | input | 2 | 00 AMI, 01 B8ZS, 10 forced ones, 11 AMI |
| line_pos | output | 1 | Positive-rail pulse |
| line_neg | output | 1 | Negative-rail pulse |
| frame_strobe | output | 1 | High while the framing bit is on the line |
| slot_idx | output | 5 | Timeslot on the line, 0 for the framing bit |

## Verification
The assertions assume that frame_load never coincides with a bit enable that sends the framing bit. They do not assume anything about the spacing of bit enables. The stimulus therefore issues every load halfway through a frame. It drives bit_en with an irregular gap pattern and changes zs_mode in mid-frame, so the sampling at the frame boundary is exercised. The data patterns include all-zero frames, sparse octets whose zero runs cross timeslot and frame edges, and dense mixed octets.

// File: rtl/t1_tx_pkg.sv
package t1_tx_pkg;
  localparam int DEF_SLOTS = 24;
  localparam int DEF_OCT_W = 8;
  localparam int SUB_LEN   = 8;   // substitution window length

  typedef enum logic [1:0] {
    ZS_AMI   = 2'b00,
    ZS_B8ZS  = 2'b01,
    ZS_FORCE = 2'b10,
    ZS_RSVD  = 2'b11
  } zs_mode_e;
endpackage

// File: rtl/t1_frame_seq.sv
module t1_frame_seq
  import t1_tx_pkg::*;
#(
  parameter int N_SLOTS = DEF_SLOTS,
  parameter int OCT_W   = DEF_OCT_W,
  localparam int DATA_W = N_SLOTS * OCT_W,
  localparam int SLOT_W = $clog2(N_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_load,
  input  logic [DATA_W-1:0] slot_data,
  input  logic              fbit,
  input  logic [1:0]        zs_mode,
  output logic              src_dat,
  output logic              src_b8,
  output logic [SLOT_W-1:0] src_slot
);
  localparam int FRAME_BITS = DATA_W + 1;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int BIT_W      = $clog2(OCT_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);

  logic [DATA_W-1:0] stg_q, stg_d, wrk_q, wrk_d;
  logic              stg_f_q, stg_f_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  zs_mode_e          mode_q, mode_d;

  logic [POS_W-1:0]  rel;
  logic [POS_W-1:0]  slot_sel;
  logic [BIT_W-1:0]  bit_sel;
  logic [OCT_W-1:0]  octet, octet_sh;
  logic              at_frame;

  assign at_frame = (pos_q == '0);
  assign rel      = pos_q - POS_W'(1);
  assign slot_sel = rel / POS_W'(OCT_W);
  assign bit_sel  = BIT_W'(rel % POS_W'(OCT_W));

  always_comb begin
    octet = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (slot_sel == POS_W'(s)) octet = wrk_q[s*OCT_W +: OCT_W];
    end
  end

  assign octet_sh = octet << bit_sel;

  // bit source for the current frame position
  always_comb begin
    if (at_frame) begin
      src_dat  = stg_f_q;
      src_b8   = (zs_mode_e'(zs_mode) == ZS_B8ZS);
      src_slot = '0;
    end else begin
      src_dat  = octet_sh[OCT_W-1];
      if (mode_q == ZS_FORCE && octet == '0 && bit_sel == BIT_W'(OCT_W - 1))
        src_dat = 1'b1;
      src_b8   = (mode_q == ZS_B8ZS);
      src_slot = SLOT_W'(slot_sel + POS_W'(1));
    end
  end

  always_comb begin
    stg_d   = stg_q;
    stg_f_d = stg_f_q;
    wrk_d   = wrk_q;
    mode_d  = mode_q;
    pos_d   = pos_q;
    if (bit_en) begin
      pos_d = (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);
      if (at_frame) begin
        wrk_d  = stg_q;
        mode_d = zs_mode_e'(zs_mode);
      end
    end
    if (frame_load) begin
      stg_d   = slot_data;
      stg_f_d = fbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q   <= '0;
      stg_f_q <= 1'b0;
      wrk_q   <= '0;
      mode_q  <= ZS_AMI;
      pos_q   <= '0;
    end else begin
      stg_q   <= stg_d;
      stg_f_q <= stg_f_d;
      wrk_q   <= wrk_d;
      mode_q  <= mode_d;
      pos_q   <= pos_d;
    end
  end

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST) else $error("position out of range");

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pos_q == POS_LAST) |=> (pos_q == '0)) else $error("frame did not wrap");

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && at_frame) |=> $stable(mode_q)) else $error("mode changed mid-frame");

  assert_wrk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && at_frame) |=> $stable(wrk_q)) else $error("working frame changed mid-frame");
endmodule

// File: rtl/t1_line_enc.sv
module t1_line_enc
  import t1_tx_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int LOOK   = SUB_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              in_dat,
  input  logic              in_b8,
  input  logic [SLOT_W-1:0] in_slot,
  output logic              line_pos,
  output logic              line_neg,
  output logic              frame_strobe,
  output logic [SLOT_W-1:0] slot_idx
);
  localparam int CNT_W = $clog2(LOOK);
  localparam int HEAD  = LOOK - 1;

  logic [LOOK-1:0]   vld_q, vld_d, dat_q, dat_d, b8_q, b8_d;
  logic [SLOT_W-1:0] slot_q [LOOK];
  logic [SLOT_W-1:0] slot_d [LOOK];
  logic              last_q, last_d;      // 1: most recent pulse was positive
  logic              sub_act_q, sub_act_d;
  logic [CNT_W-1:0]  sub_cnt_q, sub_cnt_d;
  logic              pos_d, neg_d, str_d;
  logic [SLOT_W-1:0] sidx_d;

  logic              win_zero, start, active, mark, pol;
  logic [CNT_W-1:0]  idx;

  assign win_zero = (&vld_q) && !(|dat_q) && (&b8_q);
  assign start    = !sub_act_q && win_zero;
  assign active   = sub_act_q || start;
  assign idx      = start ? '0 : sub_cnt_q;

  // look-ahead delay line, oldest bit at HEAD
  always_comb begin
    vld_d = {vld_q[LOOK-2:0], 1'b1};
    dat_d = {dat_q[LOOK-2:0], in_dat};
    b8_d  = {b8_q[LOOK-2:0], in_b8};
    slot_d[0] = in_slot;
    for (int i = 1; i < LOOK; i++) slot_d[i] = slot_q[i-1];
  end

  // symbol selection and polarity tracking
  always_comb begin
    mark      = 1'b0;
    pol       = 1'b0;
    sub_act_d = sub_act_q;
    sub_cnt_d = sub_cnt_q;
    if (active) begin
      case (idx)
        CNT_W'(3), CNT_W'(6): begin mark = 1'b1; pol = last_q;  end
        CNT_W'(4), CNT_W'(7): begin mark = 1'b1; pol = !last_q; end
        default:              begin mark = 1'b0; pol = 1'b0;    end
      endcase
      sub_cnt_d = idx + CNT_W'(1);
      sub_act_d = (idx != CNT_W'(HEAD));
    end else if (vld_q[HEAD] && dat_q[HEAD]) begin
      mark = 1'b1;
      pol  = !last_q;
    end
    last_d = mark ? pol : last_q;
    pos_d  = mark && pol;
    neg_d  = mark && !pol;
    str_d  = vld_q[HEAD] && (slot_q[HEAD] == '0);
    sidx_d = vld_q[HEAD] ? slot_q[HEAD] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q        <= '0;
      dat_q        <= '0;
      b8_q         <= '0;
      last_q       <= 1'b0;
      sub_act_q    <= 1'b0;
      sub_cnt_q    <= '0;
      line_pos     <= 1'b0;
      line_neg     <= 1'b0;
      frame_strobe <= 1'b0;
      slot_idx     <= '0;
    end else if (bit_en) begin
      vld_q        <= vld_d;
      dat_q        <= dat_d;
      b8_q         <= b8_d;
      last_q       <= last_d;
      sub_act_q    <= sub_act_d;
      sub_cnt_q    <= sub_cnt_d;
      line_pos     <= pos_d;
      line_neg     <= neg_d;
      frame_strobe <= str_d;
      slot_idx     <= sidx_d;
    end
  end

  generate
    for (genvar g = 0; g < LOOK; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      slot_q[g] <= '0;
        else if (bit_en) slot_q[g] <= slot_d[g];
      end
    end
  endgenerate

  assert_rails_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg)) else $error("both rails high");

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({line_pos, line_neg, frame_strobe, slot_idx})) else $error("output moved without enable");

  assert_sub_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sub_act_q |-> (sub_cnt_q != '0)) else $error("substitution counter stuck");

  assert_strobe_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (slot_idx == '0)) else $error("strobe outside framing bit");
endmodule

// File: rtl/t1_tx_coder.sv
module t1_tx_coder
  import t1_tx_pkg::*;
#(
  parameter int N_SLOTS = DEF_SLOTS,
  parameter int OCT_W   = DEF_OCT_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bit_en,
  input  logic                             frame_load,
  input  logic [N_SLOTS*OCT_W-1:0]         slot_data,
  input  logic                             fbit,
  input  logic [1:0]                       zs_mode,
  output logic                             line_pos,
  output logic                             line_neg,
  output logic                             frame_strobe,
  output logic [$clog2(N_SLOTS+1)-1:0]     slot_idx
);
  localparam int SLOT_W = $clog2(N_SLOTS + 1);

  logic              src_dat;
  logic              src_b8;
  logic [SLOT_W-1:0] src_slot;

  t1_frame_seq #(.N_SLOTS(N_SLOTS), .OCT_W(OCT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .frame_load (frame_load),
    .slot_data  (slot_data),
    .fbit       (fbit),
    .zs_mode    (zs_mode),
    .src_dat    (src_dat),
    .src_b8     (src_b8),
    .src_slot   (src_slot)
  );

  t1_line_enc #(.SLOT_W(SLOT_W), .LOOK(SUB_LEN)) u_enc (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .in_dat       (src_dat),
    .in_b8        (src_b8),
    .in_slot      (src_slot),
    .line_pos     (line_pos),
    .line_neg     (line_neg),
    .frame_strobe (frame_strobe),
    .slot_idx     (slot_idx)
  );
endmodule

// File: tb/t1_tx_coder_tb.sv
module t1_tx_coder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bit_en = 1'b0;
  logic         frame_load = 1'b0;
  logic [191:0] slot_data = '0;
  logic         fbit = 1'b0;
  logic [1:0]   zs_mode = 2'b00;
  logic         line_pos, line_neg, frame_strobe;
  logic [4:0]   slot_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  t1_tx_coder u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_load(frame_load),
    .slot_data(slot_data), .fbit(fbit), .zs_mode(zs_mode),
    .line_pos(line_pos), .line_neg(line_neg),
    .frame_strobe(frame_strobe), .slot_idx(slot_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int   mpos, mmode, sub_left, lastp;
  logic [7:0] stg [24];
  logic [7:0] wrk [24];
  logic       stg_f;
  int   qd[$], qm[$], qs[$];
  logic e_pos, e_neg, e_str;
  int   e_slot;
  logic be_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpos = 0; mmode = 0; sub_left = 0; lastp = 0; stg_f = 0;
      for (int i = 0; i < 24; i++) begin stg[i] = 0; wrk[i] = 0; end
      qd.delete(); qm.delete(); qs.delete();
      e_pos = 0; e_neg = 0; e_str = 0; e_slot = 0; be_seen = 0;
    end else begin
      be_seen = bit_en;
      if (bit_en) begin
        int nb, nm, ns;
        logic [7:0] oct;
        if (mpos == 0) begin
          nb = stg_f; nm = (zs_mode == 2'b01); ns = 0;
        end else begin
          oct = wrk[(mpos-1)/8];
          nb = oct[7 - (mpos-1)%8];
          if (mmode == 2 && oct == 0 && (mpos-1)%8 == 7) nb = 1;   // R7
          nm = (mmode == 1); ns = (mpos-1)/8 + 1;
        end
        if (qd.size() == 8) begin
          int allz, mark, pol;
          allz = 1;
          for (int i = 0; i < 8; i++) if (qd[i] != 0 || qm[i] == 0) allz = 0;
          if (sub_left == 0 && allz == 1) sub_left = 8;             // R6 R10
          mark = 0; pol = 0;
          if (sub_left > 0) begin
            int k;
            k = 8 - sub_left;
            if (k == 3 || k == 6) begin mark = 1; pol = lastp; end
            else if (k == 4 || k == 7) begin mark = 1; pol = 1 - lastp; end
            sub_left--;
          end else if (qd[0] != 0) begin
            mark = 1; pol = 1 - lastp;
          end
          e_pos = (mark == 1 && pol == 1);
          e_neg = (mark == 1 && pol == 0);
          if (mark == 1) lastp = pol;
          e_slot = qs[0];
          e_str  = (qs[0] == 0);
          void'(qd.pop_front()); void'(qm.pop_front()); void'(qs.pop_front());
        end
        qd.push_back(nb); qm.push_back(nm); qs.push_back(ns);
        if (mpos == 0) begin
          for (int i = 0; i < 24; i++) wrk[i] = stg[i];
          mmode = zs_mode;                                           // R8
        end
        mpos = (mpos == 192) ? 0 : mpos + 1;
      end
      if (frame_load) begin                                          // R9
        for (int i = 0; i < 24; i++) stg[i] = slot_data[i*8 +: 8];
        stg_f = fbit;
      end
    end
  end

  // ---------------- per-clock comparison and line observer ----------------
  logic started = 1'b0;
  int   viol = 0, marks = 0, obs_last = 0;

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      checks++;
      if (line_pos !== e_pos || line_neg !== e_neg) begin
        errors++;
        $display("FAIL R4 R5 R6 R7 rails got %b%b exp %b%b at cycle %0d", line_pos, line_neg, e_pos, e_neg, cyc);
      end
      checks++;
      if (frame_strobe !== e_str) begin
        errors++;
        $display("FAIL R2 strobe got %b exp %b at cycle %0d", frame_strobe, e_str, cyc);
      end
      checks++;
      if (int'(slot_idx) != e_slot) begin
        errors++;
        $display("FAIL R3 slot_idx got %0d exp %0d at cycle %0d", slot_idx, e_slot, cyc);
      end
      if (be_seen && (line_pos || line_neg)) begin
        marks++;
        if ((line_pos ? 1 : 0) == obs_last) viol++;
        obs_last = line_pos ? 1 : 0;
      end
    end
    bit_en = rst_n && (cyc % 7 != 3) && (cyc % 11 != 5);
  end

  // ---------------- stimulus ----------------
  function automatic logic [7:0] pat_byte(int pat, int s);
    case (pat)
      0: return 8'((s * 37 + 11) ^ (s << 4));
      1: return (s % 6 == 2) ? 8'h81 : ((s == 10) ? 8'h10 : 8'h00);
      default: return 8'h00;
    endcase
  endfunction

  task automatic wait_pos(int p);
    do @(negedge clk); while (mpos != p);
  endtask

  task automatic check_cond(bit ok, string msg, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", msg, act, expv);
    end
  endtask

  // load at mid-frame, measure a window of the next frame
  task automatic run_phase(int pat, logic [1:0] m, logic f);
    wait_pos(100);
    for (int s = 0; s < 24; s++) slot_data[s*8 +: 8] = pat_byte(pat, s + 1);
    fbit = f; zs_mode = m; frame_load = 1'b1;
    @(negedge clk);
    frame_load = 1'b0;
    wait_pos(20);
    viol = 0; marks = 0;
    wait_pos(150);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check_cond(line_pos == 0 && line_neg == 0, "R1 rails in reset", int'({line_pos, line_neg}), 0);
    check_cond(frame_strobe == 0 && slot_idx == 0, "R1 strobe/slot in reset", int'(slot_idx), 0);
    rst_n = 1'b1;
    started = 1'b1;

    // R5: plain AMI on mixed data, no violations allowed
    run_phase(0, 2'b00, 1'b1);
    check_cond(viol == 0, "R5 AMI violations", viol, 0);
    check_cond(marks > 0, "R5 AMI marks present", marks, 1);

    // R6 R10: B8ZS on sparse data, runs cross slot and frame edges
    run_phase(1, 2'b01, 1'b0);
    check_cond(viol > 0, "R6 B8ZS violations seen", viol, 1);
    wait_pos(100);
    wait_pos(150);

    // R7: forced ones on all-zero octets
    run_phase(2, 2'b10, 1'b0);
    check_cond(viol == 0, "R7 forced-ones violations", viol, 0);
    check_cond(marks > 0, "R7 stuffed marks present", marks, 1);

    // R8: reserved code behaves as AMI, all-zero frame is silent
    run_phase(2, 2'b11, 1'b0);
    check_cond(marks == 0, "R8 reserved mode marks", marks, 0);

    // R6: back to B8ZS on an all-zero frame
    run_phase(2, 2'b01, 1'b0);
    check_cond(viol > 0, "R6 B8ZS on empty frame", viol, 1);

    // R9 R3: final mixed frame under AMI
    run_phase(0, 2'b00, 1'b0);
    check_cond(viol == 0, "R9 AMI after reload", viol, 0);
    wait_pos(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    while (n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    errors++;
    $display("FAIL watchdog expired got %0d cycles exp fewer", n);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule